// File: doc/BRIEF.md
# Synchronous Stoppable Clock Gate Controller

This block takes one running reference clock and fans it out into a set of gated output clocks. Any output that is not exempt can be halted and later restarted with no glitch. A halt comes from either of two sources. One is an active-low external stop pin. The other is a stop control bit written through a simple register write strobe. The outputs stop when either source is low. A stopped output is held at logic low, and every stoppable output restarts on the same reference edge.

Each output has its own free-run bit. When that bit is set, the output keeps following the reference clock whatever the stop sources do. The external pin passes through a two-flop synchroniser in the reference clock domain. The gate enables are captured on the falling reference edge, so they only change while the clock is low. The status readback returns 0 whenever the stoppable outputs are halted. It reports the combined stop state, not the stored register value.

In a larger chip the block sits just after the clock source. A power manager drives the pin, and software sets the stop bit and the free-run masks.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rstN` is low, every output follows `clkIn`, `stopStatus` reads 1, and the stop bit returns to 1 (run).
- R2: Suppose the stop pin is first sampled low at rising edge n, with the stop bit at 1. Then stoppable outputs still pulse in the high phase after edge n+1, and are suppressed from the high phase after edge n+2 onward.
- R3: A write with `stopWrEn` high is sampled on a rising edge and loads `stopWrData` into the stop bit. Writing 0 at edge n suppresses stoppable outputs from the high phase after edge n+1. While the stop bit is 0, raising the pin does not restart them.
- R4: A stopped output stays at logic low for the whole time it is stopped, in both clock phases.
- R5: An output whose bit in `freeRunMask` is 1 follows `clkIn` regardless of either stop source. A mask change present at a falling edge takes effect in the high phase that follows it.
- R6: Suppose the pin is first sampled high at edge n, with the stop bit at 1. Then every stoppable output resumes in the high phase after edge n+2, within two output periods, and all of them resume on the same edge.
- R7: After rising edge n, `stopStatus` equals the stop bit AND the pin value sampled at edge n-1. It reads 0 whenever either source is low.
- R8: Every high pulse on any output lasts exactly one full high phase of `clkIn`, so no runt pulses appear.
- R9: The stop pin must be stable for at least 10 ns before the rising edge that samples it. This is a timing assumption on the environment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stpPinN | input | 1 | External stop request, active low, asynchronous |
| stopWrEn | input | 1 | Write strobe for the stop bit |
| stopWrData | input | 1 | Value written to the stop bit (0 = stop) |
| freeRunMask | input | NUM_OUTS | Per-output free-run bits (1 = ignore stop) |
| clkOut | output | NUM_OUTS | Gated output clocks |
| stopStatus | output | 1 | Combined run status, 0 when stoppable outputs are halted |

## Verification
The bench builds the block with `NUM_OUTS = 5`. With five outputs, mixed masks can hold some outputs free-running while several others stop and restart. That makes a same-edge restart across more than one stoppable output observable. Five outputs also give random masks a spread of patterns wide enough to catch a mask bit that is misrouted to a neighbouring output.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;

  // Strobes from the stop control to the gating datapath.
  typedef struct packed {
    logic runReq;   // 1 = stoppable outputs may run
  } gateCtrl_t;

endpackage

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_gate_pkg::*;
(
  input  logic      clkIn,
  input  logic      rstN,
  input  logic      stpPinN,
  input  logic      stopWrEn,
  input  logic      stopWrData,
  output gateCtrl_t ctrl,
  output logic      stopStatus
);

  localparam int SyncDepth = 2;

  logic [SyncDepth-1:0] syncQ;
  logic                 regBit;
  logic                 settled;

  // Two-flop synchroniser for the asynchronous stop pin; resets to "run".
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SyncDepth-2:0], stpPinN};
    end
  end

  // Register-held stop control bit.
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      regBit <= 1'b1;
    end else if (stopWrEn) begin
      regBit <= stopWrData;
    end
  end

  // Marks that at least one edge has passed since reset (used by checks).
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      settled <= 1'b0;
    end else begin
      settled <= 1'b1;
    end
  end

  // Either source low halts the stoppable outputs.
  always_comb begin
    ctrl.runReq = regBit & syncQ[SyncDepth-1];
    stopStatus  = ctrl.runReq;
  end

  // A write lands in the stop bit on the next edge.
  p_reg_write_r3: assert property (@(posedge clkIn) disable iff (!rstN)
    stopWrEn |=> (regBit == $past(stopWrData)));

  // Pin low on two successive sampling edges forces the status to read 0.
  p_status_pin_r7: assert property (@(posedge clkIn) disable iff (!rstN)
    (settled && !stpPinN && $past(!stpPinN)) |=> !stopStatus);

endmodule

// File: rtl/clk_gate_path.sv
module clk_gate_path
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUTS = 4
) (
  input  logic                clkIn,
  input  logic                rstN,
  input  gateCtrl_t           ctrl,
  input  logic [NUM_OUTS-1:0] freeRunMask,
  output logic [NUM_OUTS-1:0] clkOut
);

  logic [NUM_OUTS-1:0] gateEn;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_gate
    // Enable captured while the clock is low, so the AND gate cannot chop a pulse.
    always_ff @(negedge clkIn or negedge rstN) begin
      if (!rstN) begin
        gateEn[i] <= 1'b1;
      end else begin
        gateEn[i] <= freeRunMask[i] | ctrl.runReq;
      end
    end

    assign clkOut[i] = clkIn & gateEn[i];

    // A free-running output is never gated off.
    p_free_run_r5: assert property (@(posedge clkIn) disable iff (!rstN)
      (freeRunMask[i] && $past(freeRunMask[i])) |-> gateEn[i]);

    // A stoppable output parks once the control withdraws its run request.
    p_park_low_r4: assert property (@(posedge clkIn) disable iff (!rstN)
      ($past(rstN) && !ctrl.runReq && !freeRunMask[i]) |-> !gateEn[i]);

    // When the run request is present every output is enabled together.
    p_resume_r6: assert property (@(posedge clkIn) disable iff (!rstN)
      ($past(rstN) && ctrl.runReq) |-> gateEn[i]);
  end

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUTS = 4
) (
  input  logic                clkIn,
  input  logic                rstN,
  input  logic                stpPinN,
  input  logic                stopWrEn,
  input  logic                stopWrData,
  input  logic [NUM_OUTS-1:0] freeRunMask,
  output logic [NUM_OUTS-1:0] clkOut,
  output logic                stopStatus
);

  gateCtrl_t ctrl;

  clk_stop_ctrl u_ctrl (
    .clkIn      (clkIn),
    .rstN       (rstN),
    .stpPinN    (stpPinN),
    .stopWrEn   (stopWrEn),
    .stopWrData (stopWrData),
    .ctrl       (ctrl),
    .stopStatus (stopStatus)
  );

  clk_gate_path #(.NUM_OUTS(NUM_OUTS)) u_path (
    .clkIn       (clkIn),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .freeRunMask (freeRunMask),
    .clkOut      (clkOut)
  );

endmodule

// File: tb/clk_stop_gate_bench.sv
module clk_stop_gate_bench;

  localparam int N = 5;
  localparam int HalfPer = 10;

  logic         clkIn = 1'b0;
  logic         rstN;
  logic         stpPinN;
  logic         stopWrEn;
  logic         stopWrData;
  logic [N-1:0] freeRunMask;
  logic [N-1:0] clkOut;
  logic         stopStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state (requirement-level timing).
  logic mSync1 = 1'b1, mSync2 = 1'b1, mReg = 1'b1, mRun = 1'b1;
  logic [N-1:0] lastSample;

  clk_stop_gate #(.NUM_OUTS(N)) u_clk_stop_gate (
    .clkIn(clkIn), .rstN(rstN), .stpPinN(stpPinN), .stopWrEn(stopWrEn),
    .stopWrData(stopWrData), .freeRunMask(freeRunMask), .clkOut(clkOut),
    .stopStatus(stopStatus)
  );

  always #HalfPer clkIn = ~clkIn;

  function automatic logic [N-1:0] expGate(input logic [N-1:0] mask, input logic run);
    return mask | {N{run}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R8: pulse width monitor, R4: low-phase parking monitor (per-output counters).
  int runtErr [N];
  int runtCnt [N];
  time riseT [N];
  for (genvar i = 0; i < N; i++) begin : g_mon
    initial begin runtErr[i] = 0; runtCnt[i] = 0; riseT[i] = 0; end
    always @(posedge clkOut[i]) riseT[i] = $time;
    always @(negedge clkOut[i]) begin
      runtCnt[i]++;
      if (($time - riseT[i]) != HalfPer) begin
        runtErr[i]++;
        $display("FAIL R8: out %0d width %0t expected %0d", i, $time - riseT[i], HalfPer);
      end
    end
  end

  int lowErr = 0;
  always @(negedge clkIn) begin
    #1;
    if (clkOut !== '0) begin
      lowErr++;
      $display("FAIL R4: clkOut %0h expected 0 in low phase", clkOut);
    end
  end

  // R9: stimulus setup-time assumption on the stop pin.
  time lastPinChange = 0;
  int setupErr = 0;
  always @(stpPinN) lastPinChange = $time;
  always @(posedge clkIn) begin
    if (rstN === 1'b1 && lastPinChange != 0 && ($time - lastPinChange) < 10) setupErr++;
  end

  task automatic stepCycle(input logic pin, input logic wr, input logic wd,
                           input logic [N-1:0] mask, input string req);
    logic [N-1:0] expOut;
    stpPinN = pin; stopWrEn = wr; stopWrData = wd; freeRunMask = mask;
    @(posedge clkIn);
    expOut = expGate(mask, mRun);
    mSync2 = mSync1;
    mSync1 = pin;
    if (wr) mReg = wd;
    mRun = mReg & mSync2;
    #5;
    lastSample = clkOut;
    chk(clkOut === expOut, req, 32'(clkOut), 32'(expOut));
    chk(stopStatus === mRun, "R7", 32'(stopStatus), 32'(mRun));
  endtask

  initial begin
    #(200000 * 2 * HalfPer);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    int firstOn [N];
    int stpHold;
    logic pinR;
    seedVal = $urandom(32'h1d5c);
    rstN = 1'b0; stpPinN = 1'b0; stopWrEn = 1'b1; stopWrData = 1'b0; freeRunMask = '0;

    // R1: reset state, even with both stop sources low at the inputs.
    repeat (3) @(posedge clkIn);
    #5;
    chk(clkOut === '1, "R1", 32'(clkOut), 32'h1f);
    chk(stopStatus === 1'b1, "R1", 32'(stopStatus), 1);
    stpPinN = 1'b1; stopWrEn = 1'b0;
    @(posedge clkIn); #5;
    rstN = 1'b1;

    repeat (3) stepCycle(1'b1, 1'b0, 1'b0, '0, "R1");
    // R2: pin stop; model gives suppression from two edges after sampling.
    stepCycle(1'b0, 1'b0, 1'b0, '0, "R2");
    chk(lastSample === '1, "R2", 32'(lastSample), 32'h1f);
    stepCycle(1'b0, 1'b0, 1'b0, '0, "R2");
    chk(lastSample === '1, "R2", 32'(lastSample), 32'h1f);
    stepCycle(1'b0, 1'b0, 1'b0, '0, "R2");
    chk(lastSample === '0, "R2", 32'(lastSample), 0);
    repeat (3) stepCycle(1'b0, 1'b0, 1'b0, '0, "R4");
    // R5: free-run outputs while stopped.
    repeat (3) stepCycle(1'b0, 1'b0, 1'b0, 5'b00101, "R5");
    chk(lastSample === 5'b00101, "R5", 32'(lastSample), 32'h05);
    // R6: release and same-edge restart of the stoppable outputs.
    for (int i = 0; i < N; i++) firstOn[i] = -1;
    for (int c = 0; c < 4; c++) begin
      stepCycle(1'b1, 1'b0, 1'b0, 5'b00101, "R6");
      for (int i = 0; i < N; i++) if (lastSample[i] && firstOn[i] < 0) firstOn[i] = c;
    end
    chk(firstOn[1] == 2, "R6", 32'(firstOn[1]), 2);
    chk(firstOn[1] == firstOn[3] && firstOn[3] == firstOn[4], "R6",
        32'(firstOn[3]), 32'(firstOn[1]));
    // R3: register stop, then pin release does not restart while bit is 0.
    stepCycle(1'b1, 1'b1, 1'b0, '0, "R3");
    stepCycle(1'b1, 1'b0, 1'b0, '0, "R3");
    chk(lastSample === '0, "R3", 32'(lastSample), 0);
    chk(stopStatus === 1'b0, "R3", 32'(stopStatus), 0);
    repeat (2) stepCycle(1'b0, 1'b0, 1'b0, '0, "R3");
    repeat (4) stepCycle(1'b1, 1'b0, 1'b0, '0, "R3");
    chk(lastSample === '0, "R3", 32'(lastSample), 0);
    stepCycle(1'b1, 1'b1, 1'b1, '0, "R3");
    repeat (2) stepCycle(1'b1, 1'b0, 1'b0, '0, "R3");
    chk(lastSample === '1, "R3", 32'(lastSample), 32'h1f);

    // Random phase: sticky pin, rare writes, random masks.
    pinR = 1'b1; stpHold = 0;
    for (int c = 0; c < 400; c++) begin
      logic wr, wd;
      if (stpHold == 0) begin pinR = ~pinR; stpHold = 1 + int'($urandom_range(6)); end
      else stpHold--;
      wr = ($urandom_range(9) == 0);
      wd = ($urandom_range(3) != 0);
      stepCycle(pinR, wr, wd, N'($urandom), "R5");
    end
    stepCycle(1'b1, 1'b1, 1'b1, '0, "R6");
    repeat (3) stepCycle(1'b1, 1'b0, 1'b0, '0, "R6");

    // Summarise monitors.
    for (int i = 0; i < N; i++) begin
      chk(runtErr[i] == 0 && runtCnt[i] > 0, "R8", 32'(runtErr[i]), 0);
    end
    chk(lowErr == 0, "R4", 32'(lowErr), 0);
    chk(setupErr == 0, "R9", 32'(setupErr), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule